// File: doc/BRIEF.md
# USB OUT Endpoint Control and Status

This block holds the control and status byte of one USB device OUT endpoint and keeps track of the packets buffered for it. The serial interface engine reports each received packet, with its error status, and each STALL handshake it has sent. From these reports the block counts the buffered packets and raises a ready flag with a one-cycle interrupt pulse. It also keeps the endpoint's data toggle and reports overrun and data errors in isochronous mode. The FIFO memory and the byte counters sit outside this block. When a flush drops a packet, the block pulses an output that tells the FIFO to rewind its read pointer.

Software reaches the block through one byte register, decoded at address 0x14. Software releases a packet by writing 0 to the ready bit. A flush request drops exactly one packet and then clears itself. With double buffering enabled, a second packet can wait behind the first. Releasing the first packet then hands the second one to software on the next cycle, with a fresh interrupt.

Top module: `usb_out_ep_ctl`

## Requirements
- R1: After reset the register reads 0x00, and stall_req, data_toggle, ep_irq, fifo_full and fifo_rewind are all low.
- R2: A register write with bit 7 (toggle clear) set drives data_toggle to 0 from the next cycle on. Bit 7 always reads 0.
- R3: Bit 6 (stall sent) becomes 1 in the cycle after sie_stall_sent. Writing 0 to it clears it, and writing 1 leaves it unchanged.
- R4: Bit 5 (stall request) holds the last value written to it. stall_req equals that bit while iso_mode is low and is 0 while iso_mode is high.
- R5: A write with bit 4 (flush) set makes bit 4 read 1 for exactly one cycle. In that cycle, if any packet is buffered, fifo_rewind is high, the oldest packet is dropped and bit 0 clears. Each flush drops one packet at most.
- R6: In ISO mode, a stored packet with sie_pkt_err high makes bit 3 (data error) read 1 while that packet is the one presented with bit 0. Bit 3 clears when the packet is released, and writes to bit 3 have no effect.
- R7: In ISO mode, a packet that arrives while the buffer is full sets bit 2 (overrun). Writing 0 to bit 2 clears it, and writing 1 leaves it unchanged.
- R8: Bit 1 and fifo_full are 1 when the buffered count reaches 2 with dbuf_en high, or reaches 1 with dbuf_en low. Writes to bit 1 have no effect.
- R9: A packet stored while nothing is presented sets bit 0 (ready) in the next cycle. In that same cycle ep_irq is high, and it stays high for exactly that one cycle.
- R10: With two packets buffered, writing 0 to bit 0 makes bit 0 read 0 for one cycle. The bit then reads 1 again with a new ep_irq pulse.
- R11: In non-ISO mode each stored error-free packet inverts data_toggle. A packet refused because the buffer is full leaves data_toggle unchanged, and so does any packet in ISO mode.
- R12: In non-ISO mode a packet with sie_pkt_err high is discarded. The count, bit 0, bit 2 and data_toggle all stay unchanged.
- R13: Writes to any address other than 0x14 have no effect. cpu_rdata is 0x00 unless cpu_rd is high and cpu_addr is 0x14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_addr | input | ADDR_W | Register address |
| cpu_wr | input | 1 | Write strobe |
| cpu_rd | input | 1 | Read strobe |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data |
| sie_pkt_valid | input | 1 | A packet was received this cycle |
| sie_pkt_err | input | 1 | The received packet had a CRC or bit-stuffing error |
| sie_stall_sent | input | 1 | A STALL handshake was sent this cycle |
| iso_mode | input | 1 | Endpoint is in isochronous mode |
| dbuf_en | input | 1 | Double buffering enabled |
| stall_req | output | 1 | Request to answer with STALL |
| data_toggle | output | 1 | Current expected data toggle |
| ep_irq | output | 1 | One-cycle pulse when a packet is presented |
| fifo_full | output | 1 | Buffer holds its maximum number of packets |
| fifo_rewind | output | 1 | Pulse that tells the FIFO to drop one packet and rewind its read pointer |

## Verification
The bench builds the block with its defaults: two packet slots, a 6-bit address and the register at 0x14. With these values, double-buffered reloads, full-buffer refusals under both capacity settings and the wrong-address cases can all be reached within a few cycles. A cycle model in the bench follows every register bit and output. The model is driven with directed sequences first. Seeded random traffic then mixes packets, error flags, stall reports, partial register writes and mode changes.

// File: rtl/usb_out_ep_pkg.sv
package usb_out_ep_pkg;

  localparam int unsigned CSR_W = 8;

  // Read-back layout of the endpoint control byte (bit 7 first).
  typedef struct packed {
    logic tog_clr;     // always reads 0
    logic stl_sent;
    logic stl_req;
    logic flush;
    logic data_err;
    logic overrun;
    logic full;
    logic ready;
  } ep_csr_t;

  // Decoded write actions for one register write.
  typedef struct packed {
    logic tog_clr;
    logic stl_sent_clr;
    logic stl_req_wr;
    logic stl_req_val;
    logic flush_req;
    logic ovr_clr;
    logic rdy_clr;
  } ep_wr_t;

endpackage

// File: rtl/usb_out_ep_rstsync.sv
module usb_out_ep_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/usb_out_ep_csr_if.sv
module usb_out_ep_csr_if
  import usb_out_ep_pkg::*;
#(
  parameter int unsigned           ADDR_W     = 6,
  parameter logic [ADDR_W-1:0]     REG_OFFSET = 6'h14
) (
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  input  logic [CSR_W-1:0]  cpu_wdata,
  input  ep_csr_t           status,
  output ep_wr_t            wr_act,
  output logic [CSR_W-1:0]  cpu_rdata
);

  logic addr_hit;
  logic wr_hit;
  logic unused_wbits;

  assign addr_hit = (cpu_addr == REG_OFFSET);
  assign wr_hit   = cpu_wr & addr_hit;

  // Bits 3 and 1 are status only; their write data is dropped.
  assign unused_wbits = ^{cpu_wdata[3], cpu_wdata[1]};

  always_comb begin
    wr_act              = '0;
    wr_act.tog_clr      = wr_hit &  cpu_wdata[7];
    wr_act.stl_sent_clr = wr_hit & ~cpu_wdata[6];
    wr_act.stl_req_wr   = wr_hit;
    wr_act.stl_req_val  = cpu_wdata[5];
    wr_act.flush_req    = wr_hit &  cpu_wdata[4];
    wr_act.ovr_clr      = wr_hit & ~cpu_wdata[2];
    wr_act.rdy_clr      = wr_hit & ~cpu_wdata[0];
  end

  always_comb begin
    cpu_rdata = '0;
    if (cpu_rd && addr_hit) begin
      cpu_rdata = status;
    end
  end

endmodule

// File: rtl/usb_out_ep_pktq.sv
module usb_out_ep_pktq #(
  parameter int unsigned MAX_PKTS = 2,
  localparam int unsigned CNT_W   = $clog2(MAX_PKTS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pkt_valid,
  input  logic pkt_err,
  input  logic iso_mode,
  input  logic dbuf_en,
  input  logic rdy_clr,
  input  logic flush_req,
  input  logic ovr_clr,
  output logic rdy,
  output logic daterr,
  output logic ovrun,
  output logic flush_busy,
  output logic full,
  output logic irq,
  output logic rewind,
  output logic pkt_stored
);

  logic [CNT_W-1:0]    cnt_q, cnt_d, cap, wr_idx;
  logic [MAX_PKTS-1:0] err_q, err_d, err_shift;
  logic                rdy_q, rdy_d;
  logic                irq_q, irq_d;
  logic                flush_q, flush_d;
  logic                ovr_q, ovr_d;
  logic                cnt_en, err_en, rdy_en, ovr_en;
  logic                try_store, store, ovr_evt;
  logic                rel_sw, rel_fl, release_pkt, rdy_set;

  // Capacity: one packet, or all slots when double buffering.
  assign cap  = dbuf_en ? CNT_W'(MAX_PKTS) : CNT_W'(1);
  assign full = (cnt_q >= cap);

  // Non-ISO packets with errors are never stored.
  assign try_store = pkt_valid & (iso_mode | ~pkt_err);
  assign store     = try_store & ~full;
  assign ovr_evt   = pkt_valid & iso_mode & full;

  assign rel_sw      = rdy_clr & rdy_q;
  assign rel_fl      = flush_q & (cnt_q != '0);
  assign release_pkt = rel_sw | rel_fl;

  assign rdy_set = ~release_pkt & ~rdy_q & ((cnt_q != '0) | store);

  assign cnt_d  = cnt_q + CNT_W'(store) - CNT_W'(release_pkt);
  assign cnt_en = store | release_pkt;

  // Per-slot error flags: shift toward slot 0 on release, write new at tail.
  assign wr_idx = cnt_q - CNT_W'(release_pkt);

  for (genvar i = 0; i < MAX_PKTS; i++) begin : g_slot
    if (i == MAX_PKTS - 1) begin : g_top
      assign err_shift[i] = release_pkt ? 1'b0 : err_q[i];
    end else begin : g_mid
      assign err_shift[i] = release_pkt ? err_q[i+1] : err_q[i];
    end
    assign err_d[i] = (store && (wr_idx == CNT_W'(i))) ? (iso_mode & pkt_err)
                                                       : err_shift[i];
  end
  assign err_en = store | release_pkt;

  assign rdy_d  = release_pkt ? 1'b0 : 1'b1;
  assign rdy_en = release_pkt | rdy_set;
  assign irq_d  = rdy_set;

  assign flush_d = flush_req;

  assign ovr_d  = ovr_evt ? 1'b1 : 1'b0;
  assign ovr_en = ovr_evt | ovr_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      err_q   <= '0;
      rdy_q   <= 1'b0;
      irq_q   <= 1'b0;
      flush_q <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      if (err_en) err_q <= err_d;
      if (rdy_en) rdy_q <= rdy_d;
      if (ovr_en) ovr_q <= ovr_d;
      irq_q   <= irq_d;
      flush_q <= flush_d;
    end
  end

  assign rdy        = rdy_q;
  assign daterr     = rdy_q & err_q[0];
  assign ovrun      = ovr_q;
  assign flush_busy = flush_q;
  assign irq        = irq_q;
  assign rewind     = rel_fl;
  assign pkt_stored = store;

  assert_irq_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);

  assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(MAX_PKTS));

  assert_ovrun_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_q) |-> $past(iso_mode && pkt_valid));

  assert_flush_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_q && cnt_q != '0 && !store) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

endmodule

// File: rtl/usb_out_ep_hsk.sv
module usb_out_ep_hsk (
  input  logic clk,
  input  logic rst_n,
  input  logic tog_clr,
  input  logic stall_sent,
  input  logic stl_sent_clr,
  input  logic stl_req_wr,
  input  logic stl_req_val,
  input  logic iso_mode,
  input  logic pkt_stored,
  output logic toggle,
  output logic stl_sent,
  output logic stl_req_bit,
  output logic stall_req
);

  logic tog_q, tog_d, tog_en;
  logic sent_q, sent_d, sent_en;
  logic req_q;

  assign tog_en = tog_clr | (pkt_stored & ~iso_mode);
  assign tog_d  = tog_clr ? 1'b0 : ~tog_q;

  assign sent_en = stall_sent | stl_sent_clr;
  assign sent_d  = stall_sent;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog_q  <= 1'b0;
      sent_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      if (tog_en)     tog_q  <= tog_d;
      if (sent_en)    sent_q <= sent_d;
      if (stl_req_wr) req_q  <= stl_req_val;
    end
  end

  assign toggle      = tog_q;
  assign stl_sent    = sent_q;
  assign stl_req_bit = req_q;
  assign stall_req   = req_q & ~iso_mode;

  assert_stall_seen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stall_sent |=> sent_q);

  assert_tog_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tog_clr |=> !tog_q);

  assert_tog_iso_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (iso_mode && !tog_clr) |=> $stable(tog_q));

endmodule

// File: rtl/usb_out_ep_ctl.sv
module usb_out_ep_ctl
  import usb_out_ep_pkg::*;
#(
  parameter int unsigned       ADDR_W     = 6,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 6'h14,
  parameter int unsigned       MAX_PKTS   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  input  logic [7:0]        cpu_wdata,
  output logic [7:0]        cpu_rdata,
  input  logic              sie_pkt_valid,
  input  logic              sie_pkt_err,
  input  logic              sie_stall_sent,
  input  logic              iso_mode,
  input  logic              dbuf_en,
  output logic              stall_req,
  output logic              data_toggle,
  output logic              ep_irq,
  output logic              fifo_full,
  output logic              fifo_rewind
);

  logic    rst_sync_n;
  ep_wr_t  wr_act;
  ep_csr_t status;
  logic    q_rdy, q_daterr, q_ovrun, q_flush, q_full, q_stored;
  logic    h_sent, h_req;

  usb_out_ep_rstsync u_rstsync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  usb_out_ep_csr_if #(
    .ADDR_W     (ADDR_W),
    .REG_OFFSET (REG_OFFSET)
  ) u_csr_if (
    .cpu_addr  (cpu_addr),
    .cpu_wr    (cpu_wr),
    .cpu_rd    (cpu_rd),
    .cpu_wdata (cpu_wdata),
    .status    (status),
    .wr_act    (wr_act),
    .cpu_rdata (cpu_rdata)
  );

  usb_out_ep_pktq #(
    .MAX_PKTS (MAX_PKTS)
  ) u_pktq (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .pkt_valid  (sie_pkt_valid),
    .pkt_err    (sie_pkt_err),
    .iso_mode   (iso_mode),
    .dbuf_en    (dbuf_en),
    .rdy_clr    (wr_act.rdy_clr),
    .flush_req  (wr_act.flush_req),
    .ovr_clr    (wr_act.ovr_clr),
    .rdy        (q_rdy),
    .daterr     (q_daterr),
    .ovrun      (q_ovrun),
    .flush_busy (q_flush),
    .full       (q_full),
    .irq        (ep_irq),
    .rewind     (fifo_rewind),
    .pkt_stored (q_stored)
  );

  usb_out_ep_hsk u_hsk (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .tog_clr      (wr_act.tog_clr),
    .stall_sent   (sie_stall_sent),
    .stl_sent_clr (wr_act.stl_sent_clr),
    .stl_req_wr   (wr_act.stl_req_wr),
    .stl_req_val  (wr_act.stl_req_val),
    .iso_mode     (iso_mode),
    .pkt_stored   (q_stored),
    .toggle       (data_toggle),
    .stl_sent     (h_sent),
    .stl_req_bit  (h_req),
    .stall_req    (stall_req)
  );

  always_comb begin
    status          = '0;
    status.tog_clr  = 1'b0;
    status.stl_sent = h_sent;
    status.stl_req  = h_req;
    status.flush    = q_flush;
    status.data_err = q_daterr;
    status.overrun  = q_ovrun;
    status.full     = q_full;
    status.ready    = q_rdy;
  end

  assign fifo_full = q_full;

  assert_full_refuses_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    fifo_full |-> !q_stored);

endmodule

// File: tb/usb_out_ep_ctl_bench.sv
module usb_out_ep_ctl_bench;

  localparam int CLK_PERIOD = 10;
  localparam logic [5:0] OFF = 6'h14;
  localparam int SLOTS = 2;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [5:0] cpu_addr;
  logic       cpu_wr, cpu_rd;
  logic [7:0] cpu_wdata;
  logic [7:0] cpu_rdata;
  logic       sie_pkt_valid, sie_pkt_err, sie_stall_sent, iso_mode, dbuf_en;
  logic       stall_req, data_toggle, ep_irq, fifo_full, fifo_rewind;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  // Bench model state, written from the requirements.
  int       m_cnt;
  bit [1:0] m_errq;
  bit       m_rdy, m_irq, m_flush, m_ovr, m_tog, m_sent, m_req;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_out_ep_ctl u_usb_out_ep_ctl (
    .clk (clk), .rst_n (rst_n),
    .cpu_addr (cpu_addr), .cpu_wr (cpu_wr), .cpu_rd (cpu_rd),
    .cpu_wdata (cpu_wdata), .cpu_rdata (cpu_rdata),
    .sie_pkt_valid (sie_pkt_valid), .sie_pkt_err (sie_pkt_err),
    .sie_stall_sent (sie_stall_sent), .iso_mode (iso_mode), .dbuf_en (dbuf_en),
    .stall_req (stall_req), .data_toggle (data_toggle), .ep_irq (ep_irq),
    .fifo_full (fifo_full), .fifo_rewind (fifo_rewind)
  );

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic bit m_full();
    return m_cnt >= (dbuf_en ? SLOTS : 1);
  endfunction

  function automatic bit [7:0] m_byte();
    return {1'b0, m_sent, m_req, m_flush, m_rdy & m_errq[0], m_ovr, m_full(), m_rdy};
  endfunction

  task automatic model_step(bit wr, bit [5:0] a, bit [7:0] wd, bit pv, bit pe, bit ss);
    bit hit, full, store, ovr, rel, set;
    int idx;
    hit   = wr && (a == OFF);
    full  = m_full();
    store = pv && (iso_mode || !pe) && !full;
    ovr   = pv && iso_mode && full;
    rel   = (hit && !wd[0] && m_rdy) || (m_flush && m_cnt > 0);
    set   = !rel && !m_rdy && (m_cnt > 0 || store);
    if (rel) m_errq = {1'b0, m_errq[1]};
    idx = m_cnt - (rel ? 1 : 0);
    if (store) m_errq[idx] = iso_mode && pe;
    m_cnt   = m_cnt + (store ? 1 : 0) - (rel ? 1 : 0);
    m_rdy   = rel ? 1'b0 : (m_rdy | set);
    m_irq   = set;
    m_flush = hit && wd[4];
    if (ovr) m_ovr = 1'b1; else if (hit && !wd[2]) m_ovr = 1'b0;
    if (hit && wd[7]) m_tog = 1'b0; else if (store && !iso_mode) m_tog = ~m_tog;
    if (ss) m_sent = 1'b1; else if (hit && !wd[6]) m_sent = 1'b0;
    if (hit) m_req = wd[5];
  endtask

  task automatic compare_all();
    bit [7:0] e;
    e = m_byte();
    chk("R9",  "ready bit",    cpu_rdata[0], e[0]);
    chk("R8",  "full bit",     cpu_rdata[1], e[1]);
    chk("R7",  "overrun bit",  cpu_rdata[2], e[2]);
    chk("R6",  "data err bit", cpu_rdata[3], e[3]);
    chk("R5",  "flush bit",    cpu_rdata[4], e[4]);
    chk("R4",  "stall req bit", cpu_rdata[5], e[5]);
    chk("R3",  "stall sent bit", cpu_rdata[6], e[6]);
    chk("R2",  "toggle clr bit", cpu_rdata[7], 0);
    chk("R4",  "stall_req",    stall_req, m_req & ~iso_mode);
    chk("R11", "data_toggle",  data_toggle, m_tog);
    chk("R9",  "ep_irq",       ep_irq, m_irq);
    chk("R8",  "fifo_full",    fifo_full, e[1]);
    chk("R5",  "fifo_rewind",  fifo_rewind, (m_flush && m_cnt > 0) ? 1 : 0);
  endtask

  // One clock: drive at the falling edge, let the rising edge act, check at the next falling edge.
  task automatic cycle(bit wr, bit [5:0] a, bit [7:0] wd, bit pv, bit pe, bit ss);
    cpu_wr = wr; cpu_addr = a; cpu_wdata = wd;
    sie_pkt_valid = pv; sie_pkt_err = pe; sie_stall_sent = ss;
    model_step(wr, a, wd, pv, pe, ss);
    @(posedge clk);
    @(negedge clk);
    cpu_wr = 1'b0; cpu_addr = OFF; sie_pkt_valid = 1'b0; sie_pkt_err = 1'b0;
    sie_stall_sent = 1'b0;
    #1;
    compare_all();
  endtask

  task automatic idle();      cycle(0, OFF, 8'h00, 0, 0, 0); endtask
  task automatic pkt(bit e);  cycle(0, OFF, 8'h00, 1, e, 0); endtask
  task automatic wreg(bit [7:0] d); cycle(1, OFF, d, 0, 0, 0); endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL all requirements watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : stim
    bit [7:0] wd;
    int r;
    m_cnt = 0; m_errq = '0; m_rdy = 0; m_irq = 0; m_flush = 0; m_ovr = 0;
    m_tog = 0; m_sent = 0; m_req = 0;
    rst_n = 1'b0; cpu_addr = OFF; cpu_wr = 0; cpu_rd = 1; cpu_wdata = '0;
    sie_pkt_valid = 0; sie_pkt_err = 0; sie_stall_sent = 0; iso_mode = 0; dbuf_en = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk("R1", "reset rdata", cpu_rdata, 8'h00);
    chk("R1", "reset outputs", {stall_req, data_toggle, ep_irq, fifo_full, fifo_rewind}, 0);
    compare_all();

    // Single buffering, non-ISO.
    pkt(0);
    chk("R9", "irq on first packet", ep_irq, 1);
    chk("R11", "toggle after good packet", data_toggle, 1);
    chk("R8", "full with one packet, single buffer", fifo_full, 1);
    pkt(0);
    chk("R11", "toggle kept on refused packet", data_toggle, 1);
    chk("R7", "no overrun outside ISO", cpu_rdata[2], 0);
    idle();
    chk("R9", "irq lasts one cycle", ep_irq, 0);
    wreg(8'h81);
    chk("R2", "toggle cleared", data_toggle, 0);
    chk("R2", "clear bit reads 0", cpu_rdata[7], 0);
    cycle(1, 6'h15, 8'h00, 0, 0, 0);
    chk("R13", "wrong address keeps ready", cpu_rdata[0], 1);
    cpu_addr = 6'h13; #1;
    chk("R13", "rdata zero off address", cpu_rdata, 8'h00);
    cpu_addr = OFF;
    wreg(8'h00);
    chk("R9", "ready released", cpu_rdata[0], 0);
    pkt(1);
    chk("R12", "errored packet dropped", {cpu_rdata[0], fifo_full, data_toggle}, 0);

    // Double buffering: reload after release.
    dbuf_en = 1'b1;
    pkt(0); pkt(0);
    chk("R8", "full with two packets", fifo_full, 1);
    wreg(8'h00);
    chk("R10", "ready low for one cycle", cpu_rdata[0], 0);
    chk("R10", "no irq in gap", ep_irq, 0);
    idle();
    chk("R10", "ready back", cpu_rdata[0], 1);
    chk("R10", "new irq", ep_irq, 1);
    wreg(8'h00); idle();

    // Flush one of two.
    pkt(0); pkt(0);
    wreg(8'h11);
    chk("R5", "flush bit set", cpu_rdata[4], 1);
    chk("R5", "rewind pulse", fifo_rewind, 1);
    idle();
    chk("R5", "flush self-cleared", cpu_rdata[4], 0);
    chk("R5", "one packet dropped", {fifo_full, cpu_rdata[0]}, 0);
    idle();
    chk("R5", "remaining packet presented", cpu_rdata[0], 1);
    wreg(8'h11); idle(); idle();
    chk("R5", "empty after second flush", cpu_rdata[0], 0);

    // ISO errors and overrun.
    iso_mode = 1'b1; dbuf_en = 1'b0;
    pkt(1);
    chk("R6", "data error shown", cpu_rdata[3], 1);
    pkt(0);
    chk("R7", "overrun set", cpu_rdata[2], 1);
    wreg(8'h0D);
    chk("R7", "overrun kept on write 1", cpu_rdata[2], 1);
    chk("R6", "data error ignores write", cpu_rdata[3], 1);
    wreg(8'h01);
    chk("R7", "overrun cleared", cpu_rdata[2], 0);
    wreg(8'h00);
    chk("R6", "data error cleared with ready", cpu_rdata[3], 0);

    // Stall control.
    wreg(8'h21);
    chk("R4", "no stall in ISO", stall_req, 0);
    iso_mode = 1'b0; #1;
    chk("R4", "stall outside ISO", stall_req, 1);
    cycle(0, OFF, 8'h00, 0, 0, 1);
    chk("R3", "stall sent set", cpu_rdata[6], 1);
    wreg(8'h61);
    chk("R3", "stall sent kept", cpu_rdata[6], 1);
    wreg(8'h01);
    chk("R3", "stall sent cleared", cpu_rdata[6], 0);

    // Seeded random traffic.
    r = $urandom(32'd20240611);
    for (int k = 0; k < 4000; k++) begin
      if (k % 400 == 0) begin
        iso_mode = 1'($urandom % 2);
        dbuf_en  = 1'($urandom % 2);
      end
      r = $urandom % 16;
      if (r < 3) begin
        wd = 8'($urandom);
        if ($urandom % 4 != 0) wd[0] = 1'b1;
        if ($urandom % 3 != 0) wd[2] = 1'b1;
        if ($urandom % 3 != 0) wd[6] = 1'b1;
        if ($urandom % 4 != 0) wd[4] = 1'b0;
        if ($urandom % 4 != 0) wd[7] = 1'b0;
        cycle(1, ($urandom % 8 == 0) ? 6'h15 : OFF, wd, 0, 0, 0);
      end else begin
        cycle(0, OFF, 8'h00, ($urandom % 3 == 0), ($urandom % 4 == 0),
              ($urandom % 16 == 0));
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule